// File: doc/BRIEF.md
# Shift-Only AdaMax Weight Updater

This block performs one optimizer step on a single real-valued weight each time a transaction is offered. The caller presents the current weight, the running first-moment value, the running second-moment value and a fresh gradient. The block returns the updated weight, both updated moments and the one-bit weight used by a binarized forward pass. The caller owns all storage and writes the returned values back.

No multiplier or divider is used. Both moment decays are a value minus a right-shifted copy of itself. The second moment is a running peak: the larger of its decayed value and the gradient magnitude. The step size comes from the first moment, shifted by the learning-rate exponent and then by an exponent taken from the most significant set bit of the new second moment. That exponent stands in for a power of two near the second moment's inverse. The updated weight is then clamped to the closed interval from minus one to plus one.

All values are two's-complement fixed point with `FRAC` fractional bits (16 by default) in `W` bits (24 by default), so 1.0 is 65536. The second moment is unsigned. The result is registered, so each accepted transaction produces exactly one result one clock later.

Top module: `amx_weight_update`

## Requirements
- R1: A result is registered on the edge where `in_valid` is high and appears with `out_valid` high one cycle later. `out_valid` is low after any edge where `in_valid` was low, and all result outputs then keep their previous values.
- R2: The new first moment is m − (m >>> B1_SH) + (g >>> B1_SH), with arithmetic (floor) shifts and B1_SH = 3 by default, so that 1 − β1 = 1/8.
- R3: The new second moment is the larger of v − (v >> B2_SH) and |g|, with B2_SH = 10 by default. |g| of the most negative gradient saturates to 2^(W−1) − 1.
- R4: When the new second moment is nonzero, let p be the index of its highest set bit (bit 0 = LSB). The step is the new first moment shifted left by FRAC − LR_SH − p when that value is non-negative, and otherwise shifted right arithmetically by its magnitude. LR_SH = 10 by default. The weight before clamping is w minus the step, computed without overflow.
- R5: When the new second moment is zero, no step is taken and the weight before clamping equals the input weight.
- R6: The returned weight is clamped to [−2^FRAC, +2^FRAC], that is [−1.0, +1.0].
- R7: `bin_out` is 1 (meaning +1) when the returned weight is zero or positive, and 0 (meaning −1) when it is negative.
- R8: While `rst` is high, and until the first accepted transaction after it, `out_valid` is 0 and `w_out`, `m_out`, `v_out` and `bin_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Transaction offered this cycle |
| w_in | input | W | Current weight, signed fixed point |
| m_in | input | W | Current first moment, signed fixed point |
| v_in | input | W | Current second moment, unsigned fixed point |
| g_in | input | W | Gradient, signed fixed point |
| out_valid | output | 1 | Result outputs carry a new transaction |
| w_out | output | W | Updated weight after clamping |
| m_out | output | W | Updated first moment |
| v_out | output | W | Updated second moment |
| bin_out | output | 1 | Binary weight, 1 for +1 and 0 for −1 |

## Verification
The bench builds the block with its defaults: W = 24, FRAC = 16, B1_SH = 3, B2_SH = 10, LR_SH = 10, and floor-style exponent selection. With these values the step shift ranges from six places left (second moment of one LSB) to seventeen places right (second moment at the top bit). Directed items therefore drive the weight hard into both clamp limits and also give exact sub-LSB truncation of the step. The 24-bit width keeps the most negative gradient, and the saturation of its magnitude, easy to reach. Random items spread the second moment across many exponents, so the shift amount changes direction within one run.

// File: rtl/amx_pkg.sv
package amx_pkg;

   // How the exponent standing in for 1/v is picked from the second moment
   typedef enum logic {
      AP2_FLOOR   = 1'b0,   // index of the highest set bit
      AP2_NEAREST = 1'b1    // bump by one when the next bit down is set
   } ap2_mode_e;

   // Width needed to hold a bit index in 0..n
   function automatic int idx_width(input int n);
      int r;
      r = 1;
      while ((1 << r) <= n) r++;
      return r;
   endfunction

endpackage

// File: rtl/amx_moments.sv
module amx_moments #(
   parameter int W     = 24,
   parameter int B1_SH = 3,
   parameter int B2_SH = 10
) (
   input  logic signed [W-1:0] m_in,
   input  logic        [W-1:0] v_in,
   input  logic signed [W-1:0] g_in,
   output logic signed [W-1:0] m_next,
   output logic        [W-1:0] v_next
);
   localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MINNEG = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] g_mag;
   logic [W-1:0] v_dec;

   // Decayed exponential average; the two shifted terms are bounded so no overflow
   always_comb begin
      m_next = m_in - (m_in >>> B1_SH) + (g_in >>> B1_SH);
   end

   // Magnitude of the gradient, saturating the single unrepresentable case
   always_comb begin
      if (!g_in[W-1])
         g_mag = g_in;
      else if (g_in == MINNEG)
         g_mag = MAXPOS;
      else
         g_mag = -g_in;
   end

   // Running peak with slow decay
   always_comb begin
      v_dec  = v_in - (v_in >> B2_SH);
      v_next = (v_dec > g_mag) ? v_dec : g_mag;
   end
endmodule

// File: rtl/amx_ap2_exp.sv
module amx_ap2_exp
   import amx_pkg::*;
#(
   parameter int        W    = 24,
   parameter ap2_mode_e MODE = AP2_FLOOR,
   localparam int       PW   = idx_width(W)
) (
   input  logic [W-1:0]  v_val,
   output logic [PW-1:0] exp_idx,
   output logic          v_zero
);
   logic [PW-1:0] msb_idx;

   // Priority scan: the last set bit found from the bottom wins
   always_comb begin
      msb_idx = '0;
      for (int i = 0; i < W; i++) begin
         if (v_val[i]) msb_idx = PW'(i);
      end
   end

   assign v_zero = (v_val == '0);

   generate
      if (MODE == AP2_NEAREST) begin : g_nearest
         logic below;
         always_comb begin
            below = 1'b0;
            for (int i = 1; i < W; i++) begin
               if (msb_idx == PW'(i)) below = v_val[i-1];
            end
            exp_idx = msb_idx + PW'(below);
         end
      end else begin : g_floor
         assign exp_idx = msb_idx;
      end
   endgenerate
endmodule

// File: rtl/amx_step_clip.sv
module amx_step_clip
   import amx_pkg::*;
#(
   parameter int  W     = 24,
   parameter int  FRAC  = 16,
   parameter int  LR_SH = 10,
   localparam int PW    = idx_width(W),
   localparam int SW    = W + FRAC + 2,
   localparam int BASE  = FRAC - LR_SH
) (
   input  logic signed [W-1:0]  w_in,
   input  logic signed [W-1:0]  m_next,
   input  logic        [PW-1:0] exp_idx,
   input  logic                 v_zero,
   output logic signed [W-1:0]  w_next,
   output logic                 w_bin
);
   localparam logic signed [SW-1:0] POS_ONE = SW'(1) <<< FRAC;
   localparam logic signed [SW-1:0] NEG_ONE = -(SW'(1) <<< FRAC);

   logic signed [SW-1:0] m_x;
   logic signed [SW-1:0] w_x;
   logic signed [SW-1:0] step;
   logic signed [SW-1:0] raw;
   logic signed [SW-1:0] clamped;
   int                   e;

   always_comb begin
      m_x = {{(SW-W){m_next[W-1]}}, m_next};
      w_x = {{(SW-W){w_in[W-1]}}, w_in};
      e   = int'(exp_idx);
      // Scale by lr and by the power of two nearest 1/v, in one barrel shift
      if (e <= BASE)
         step = m_x <<< (BASE - e);
      else
         step = m_x >>> (e - BASE);
      raw = v_zero ? w_x : (w_x - step);
   end

   always_comb begin
      if (raw > POS_ONE)
         clamped = POS_ONE;
      else if (raw < NEG_ONE)
         clamped = NEG_ONE;
      else
         clamped = raw;
      w_next = clamped[W-1:0];
      w_bin  = !clamped[SW-1];
   end
endmodule

// File: rtl/amx_weight_update.sv
module amx_weight_update
   import amx_pkg::*;
#(
   parameter int        W         = 24,
   parameter int        FRAC      = 16,
   parameter int        B1_SH     = 3,
   parameter int        B2_SH     = 10,
   parameter int        LR_SH     = 10,
   parameter ap2_mode_e AP2_MODE  = AP2_FLOOR
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic signed [W-1:0] w_in,
   input  logic signed [W-1:0] m_in,
   input  logic        [W-1:0] v_in,
   input  logic signed [W-1:0] g_in,
   output logic                out_valid,
   output logic signed [W-1:0] w_out,
   output logic signed [W-1:0] m_out,
   output logic        [W-1:0] v_out,
   output logic                bin_out
);
   localparam int PW = idx_width(W);

   // Elaboration-time parameter checks
   generate
      if (FRAC < 1 || FRAC > W - 2) begin : g_bad_frac
         $error("amx_weight_update: FRAC must leave room for sign and 1.0");
      end
      if (B1_SH < 1 || B1_SH >= W) begin : g_bad_b1
         $error("amx_weight_update: B1_SH out of range");
      end
      if (B2_SH < 1 || B2_SH >= W) begin : g_bad_b2
         $error("amx_weight_update: B2_SH out of range");
      end
      if (LR_SH < 0 || LR_SH >= W) begin : g_bad_lr
         $error("amx_weight_update: LR_SH out of range");
      end
   endgenerate

   logic signed [W-1:0]  m_nx;
   logic        [W-1:0]  v_nx;
   logic        [PW-1:0] e_idx;
   logic                 v_is_zero;
   logic signed [W-1:0]  w_nx;
   logic                 b_nx;

   amx_moments #(.W(W), .B1_SH(B1_SH), .B2_SH(B2_SH)) u_mom (
      .m_in   (m_in),
      .v_in   (v_in),
      .g_in   (g_in),
      .m_next (m_nx),
      .v_next (v_nx)
   );

   amx_ap2_exp #(.W(W), .MODE(AP2_MODE)) u_exp (
      .v_val   (v_nx),
      .exp_idx (e_idx),
      .v_zero  (v_is_zero)
   );

   amx_step_clip #(.W(W), .FRAC(FRAC), .LR_SH(LR_SH)) u_step (
      .w_in    (w_in),
      .m_next  (m_nx),
      .exp_idx (e_idx),
      .v_zero  (v_is_zero),
      .w_next  (w_nx),
      .w_bin   (b_nx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         w_out     <= '0;
         m_out     <= '0;
         v_out     <= '0;
         bin_out   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            w_out   <= w_nx;
            m_out   <= m_nx;
            v_out   <= v_nx;
            bin_out <= b_nx;
         end
      end
   end
endmodule

// File: rtl/amx_weight_update_chk.sv
module amx_weight_update_chk #(
   parameter int W    = 24,
   parameter int FRAC = 16
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic signed [W-1:0] w_in,
   input logic signed [W-1:0] m_in,
   input logic        [W-1:0] v_in,
   input logic signed [W-1:0] g_in,
   input logic                out_valid,
   input logic signed [W-1:0] w_out,
   input logic signed [W-1:0] m_out,
   input logic        [W-1:0] v_out,
   input logic                bin_out
);
   localparam logic signed [W-1:0] P1 = W'(1) <<< FRAC;
   localparam logic signed [W-1:0] N1 = -(W'(1) <<< FRAC);

   logic [W-1:0] gmag;
   always_comb begin
      if (!g_in[W-1])                      gmag = g_in;
      else if (g_in == {1'b1, {(W-1){1'b0}}}) gmag = {1'b0, {(W-1){1'b1}}};
      else                                 gmag = -g_in;
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid && $stable(w_out) && $stable(m_out) && $stable(v_out) && $stable(bin_out)); // R1
   AST_M_DECAYS: assert property (@(posedge clk) disable iff (rst)
      in_valid && g_in == '0 && !m_in[W-1] |=> m_out <= $past(m_in)); // R2
   AST_V_COVERS_G: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> v_out >= $past(gmag)); // R3
   AST_ZERO_V_HOLD: assert property (@(posedge clk) disable iff (rst)
      in_valid && v_in == '0 && g_in == '0 && w_in <= P1 && w_in >= N1 |=> w_out == $past(w_in)); // R5
   AST_WEIGHT_CLAMPED: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> w_out <= P1 && w_out >= N1); // R6
   AST_BIN_SIGN: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> bin_out == !w_out[W-1]); // R7
endmodule

bind amx_weight_update amx_weight_update_chk #(.W(W), .FRAC(FRAC)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .w_in      (w_in),
   .m_in      (m_in),
   .v_in      (v_in),
   .g_in      (g_in),
   .out_valid (out_valid),
   .w_out     (w_out),
   .m_out     (m_out),
   .v_out     (v_out),
   .bin_out   (bin_out)
);

// File: tb/sim_amx_weight_update.sv
`timescale 1ns/1ps
module sim_amx_weight_update;
   localparam int W = 24;
   localparam longint ONE = 64'sd1 <<< 16;
   localparam longint MAXP = (64'sd1 <<< (W-1)) - 1;
   localparam longint MINN = -(64'sd1 <<< (W-1));

   typedef struct {
      logic signed [W-1:0] w;
      logic signed [W-1:0] m;
      logic        [W-1:0] v;
      logic                b;
      string               tag;
   } exp_t;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic                in_valid = 1'b0;
   logic signed [W-1:0] w_in = '0, m_in = '0, g_in = '0;
   logic        [W-1:0] v_in = '0;
   logic                out_valid;
   logic signed [W-1:0] w_out, m_out;
   logic        [W-1:0] v_out;
   logic                bin_out;

   int   checks = 0;
   int   errors = 0;
   bit   done = 0;
   exp_t q[$];

   always #2.5 clk = ~clk;

   amx_weight_update u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .w_in(w_in), .m_in(m_in), .v_in(v_in), .g_in(g_in),
      .out_valid(out_valid), .w_out(w_out), .m_out(m_out),
      .v_out(v_out), .bin_out(bin_out)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Reference model written from the requirements
   function automatic exp_t model(input longint w, input longint m, input longint v,
                                  input longint g, input string tag);
      exp_t   r;
      longint mn, ag, vd, vn, wn, step;
      int     p, s;
      mn = m - (m >>> 3) + (g >>> 3);                      // R2
      ag = (g < 0) ? -g : g;
      if (ag > MAXP) ag = MAXP;                            // R3
      vd = v - (v >>> 10);
      vn = (vd > ag) ? vd : ag;
      if (vn == 0) wn = w;                                 // R5
      else begin
         p = 0;
         for (int i = 0; i < W; i++) if (vn[i]) p = i;
         s = 16 - 10 - p;                                  // R4
         step = (s >= 0) ? (mn <<< s) : (mn >>> (-s));
         wn = w - step;
      end
      if (wn > ONE) wn = ONE;                              // R6
      if (wn < -ONE) wn = -ONE;
      r.w = wn[W-1:0];
      r.m = mn[W-1:0];
      r.v = vn[W-1:0];
      r.b = (wn >= 0);                                     // R7
      r.tag = tag;
      return r;
   endfunction

   // Driver: called at a falling edge, leaves at the next falling edge
   task automatic send(input longint w, input longint m, input longint v,
                       input longint g, input string tag);
      q.push_back(model(w, m, v, g, tag));
      w_in = w[W-1:0]; m_in = m[W-1:0]; v_in = v[W-1:0]; g_in = g[W-1:0];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      w_in = 24'sd1234; m_in = -24'sd999; v_in = 24'd5; g_in = 24'sd77;
      repeat (n) @(negedge clk);
   endtask

   // Monitor / scoreboard
   initial begin
      logic signed [W-1:0] pw, pm;
      logic        [W-1:0] pv;
      logic                pb;
      bit                  have = 0;
      exp_t                e;
      forever begin
         @(negedge clk);
         if (rst) continue;
         if (out_valid) begin
            if (q.size() == 0) begin
               chk(0, "R1 unexpected out_valid", 1, 0);
            end else begin
               e = q.pop_front();
               chk(w_out == e.w, {"R4 R6 weight ", e.tag}, longint'(w_out), longint'(e.w));
               chk(m_out == e.m, {"R2 first moment ", e.tag}, longint'(m_out), longint'(e.m));
               chk(v_out == e.v, {"R3 second moment ", e.tag}, longint'(v_out), longint'(e.v));
               chk(bin_out == e.b, {"R7 binary weight ", e.tag}, longint'(bin_out), longint'(e.b));
            end
            have = 1;
         end else if (have) begin
            chk(w_out == pw && m_out == pm && v_out == pv && bin_out == pb,
                "R1 outputs held while idle", longint'(w_out), longint'(pw));
         end
         pw = w_out; pm = m_out; pv = v_out; pb = bin_out;
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=hang expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // Stimulus
   initial begin
      void'($urandom(11));
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R8 out_valid in reset", longint'(out_valid), 0);
      chk(w_out == '0 && m_out == '0 && v_out == '0 && bin_out == 1'b0,
          "R8 outputs cleared in reset", longint'(w_out), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 out_valid after reset", longint'(out_valid), 0);
      chk(w_out == '0 && bin_out == 1'b0, "R8 outputs stay cleared", longint'(w_out), 0);

      // Directed corners
      send(ONE, ONE, 0, 0, "R5 zero second moment");
      send(-ONE + 10, ONE, 1, 0, "R6 clamp at -1");
      idle(3);
      send(ONE - 5, -ONE, 1, 0, "R6 clamp at +1");
      send(100, 5000, 0, MINN, "R3 most negative gradient");
      send(0, 0, ONE, 0, "R7 zero weight maps to +1");
      send(300, -1, 0, 0, "R2 floor of negative moment");
      send(-200, 4096, ONE, 0, "R4 right shift step");
      send(-200, 4096, 3, 0, "R4 left shift step");
      send(1000, 800, 1 << 20, -(1 << 12), "R3 decayed peak wins");
      send(1000, 800, 100, -(1 << 12), "R3 gradient wins");
      idle(2);

      // Random items across many exponents
      for (int n = 0; n < 300; n++) begin
         longint w, m, v, g;
         int     sh;
         w  = longint'($urandom_range(0, 2 * 65536)) - ONE;
         m  = longint'($urandom_range(0, 1 << 21)) - (1 << 20);
         g  = longint'($urandom_range(0, 1 << 21)) - (1 << 20);
         sh = $urandom_range(0, 23);
         v  = longint'($urandom) & ((64'sd1 <<< sh) - 1);
         send(w, m, v, g, "R4 random");
         if ($urandom_range(0, 3) == 0) idle(1);
      end
      idle(3);
      chk(q.size() == 0, "R1 every item answered", q.size(), 0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule